// File: doc/BRIEF.md
# Radix-4 Booth Row-Accumulating Multiplier

This block multiplies a signed `A_W`-bit operand by a signed `B_W`-bit operand. It can also add an optional addend, which turns it into a multiply-accumulate. The `B_W`-bit operand is recoded into radix-4 Booth digits. Each digit chooses zero, plus or minus the first operand, or plus or minus twice the first operand, as one partial-product row. The rows are added one after another by a chain of carry-propagate adders. Each adder takes the running sum from the row above and adds its own selected multiple. The digit's negate flag goes in as a carry at the row's lowest position. There is no separate reduction tree.

Sign extension of the rows is not done by copying sign bits. The leading bit of each row is inverted instead, and one bias constant is folded into the starting sum. That bias is a pattern of leading ones that cancels the inverted bits. The first adder has a spare input, so the optional addend enters there at no extra adder cost.

The parameter `PIPE` chooses between two builds. With `PIPE=0` the block is purely combinational. With `PIPE=1` a register follows every row, and the remaining multiplier digits, the first operand and a valid flag travel through the stages alongside the partial sums.

Top module: `booth_row_mac`

## Requirements
- R1: With `acc_en`=0, `result` equals the two's-complement product `op_a`×`op_b` at full width `A_W+B_W`. Both operands are read as signed.
- R2: With `acc_en`=1, `result` equals `op_a`×`op_b` + `acc_in`, taken modulo 2^(`A_W+B_W`). `acc_in` is read as a signed `A_W+B_W`-bit value, and the sum wraps without saturation.
- R3: With `acc_en`=0, the value on `acc_in` has no effect on `result`.
- R4: The product is exact when either operand, or both, holds its most-negative value. For the default 8×8 build, −128×−128 gives 16384.
- R5: With `PIPE=1`, `out_valid` goes high exactly `B_W/2+1` clock cycles (integer division) after the cycle in which `in_valid` is high. With `PIPE=0`, `out_valid` follows `in_valid` in the same cycle.
- R6: With `PIPE=1`, operands accepted in consecutive cycles each produce one result, in issue order, one per cycle.
- R7: After reset is released, and as long as no operand has been issued, `out_valid` stays 0.
- R8: Every bit triplet (b[m+1], b[m], b[m−1]) at an even position m recodes correctly, with b[−1]=0 and bits above `B_W` taken as copies of the sign bit. The digit values are: 000 and 111 give 0; 001 and 010 give +1; 011 gives +2; 100 gives −2; 101 and 110 give −1. A product whose multiplier contains each triplet is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stage registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on the inputs are to be processed this cycle |
| op_a | input | A_W | Signed multiplicand |
| op_b | input | B_W | Signed multiplier, Booth-recoded |
| acc_in | input | A_W+B_W | Signed addend for multiply-accumulate |
| acc_en | input | 1 | 1 adds `acc_in` to the product |
| out_valid | output | 1 | `result` holds a finished value |
| result | output | A_W+B_W | Product, or product plus addend, in two's complement |

## Verification
Suppose one row gets a wrong digit control, a wrong carry injection or a stale operand copy. The damage shows on `result` in the very cycle that operand set leaves the last stage, which is `B_W/2+1` cycles after issue. It shows as a difference of a multiple of 2^m for the row at position m. A lost or duplicated valid bit shows as a missing or extra `out_valid` pulse at that same cycle. It also shifts every later result out of issue order, so back-to-back bursts with distinct operands expose it at once. A wrong bias constant offsets every result, including 0×0, starting from the first output.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  // Control bits for one radix-4 digit
  typedef struct packed {
    logic z;  // digit is zero
    logic c;  // digit is negative: invert and add one
    logic s;  // use twice the multiplicand
  } booth_ctl_t;

  function automatic booth_ctl_t booth_encode(input logic [2:0] trip);
    booth_ctl_t r;
    r = '0;
    unique case (trip)
      3'b000, 3'b111: r.z = 1'b1;
      3'b001, 3'b010: r   = '0;
      3'b011:         r.s = 1'b1;
      3'b100:         begin r.c = 1'b1; r.s = 1'b1; end
      default:        r.c = 1'b1;  // 101, 110
    endcase
    return r;
  endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_mac_pkg::*;
(
  input  logic [2:0] trip,
  output booth_ctl_t ctl
);

  always_comb ctl = booth_encode(trip);

endmodule

// File: rtl/booth_row_add.sv
module booth_row_add
  import booth_mac_pkg::*;
#(
  parameter int A_W   = 8,
  parameter int W     = 16,
  parameter int SHIFT = 0
) (
  input  logic [W-1:0]   sum_in,
  input  logic [A_W-1:0] a,
  input  booth_ctl_t     ctl,
  output logic [W-1:0]   sum_out
);

  logic [A_W:0]  mult;
  logic [A_W:0]  pp;
  logic [W-1:0]  row_w;
  logic [W-1:0]  cin_w;

  always_comb begin
    // select 0, a or 2a, each A_W+1 bits signed
    if (ctl.z)      mult = '0;
    else if (ctl.s) mult = {a, 1'b0};
    else            mult = {a[A_W-1], a};
    // one's complement for a negative digit
    pp = mult ^ {(A_W+1){ctl.c}};
    // leading bit inverted; bias constant cancels it
    row_w          = '0;
    row_w[A_W:0]   = {~pp[A_W], pp[A_W-1:0]};
    row_w          = row_w << SHIFT;
    cin_w          = '0;
    cin_w[SHIFT]   = ctl.c;
    sum_out        = sum_in + row_w + cin_w;
  end

endmodule

// File: rtl/booth_row_mac.sv
module booth_row_mac
  import booth_mac_pkg::*;
#(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  input  logic [A_W+B_W-1:0] acc_in,
  input  logic               acc_en,
  output logic               out_valid,
  output logic [A_W+B_W-1:0] result
);

  localparam int W    = A_W + B_W;
  localparam int ROWS = B_W / 2 + 1;
  localparam int BX_W = 2 * ROWS;
  localparam int Q_W  = BX_W + 1;
  localparam logic [W-1:0] ONE_W = 1;

  // Sum of -2^(A_W+2r) over all rows: the leading ones that stand in
  // for the rows' sign extension.
  function automatic logic [W-1:0] bias_const();
    logic [W-1:0] k;
    k = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (A_W + 2 * r < W) k = k - (ONE_W << (A_W + 2 * r));
    end
    return k;
  endfunction

  localparam logic [W-1:0] ROW_BIAS = bias_const();

  logic [W-1:0]   sum_p [ROWS+1];
  logic [W-1:0]   sum_n [ROWS];
  logic           vld_p [ROWS+1];
  logic [A_W-1:0] a_p   [ROWS];
  logic [Q_W-1:0] q_p   [ROWS];
  booth_ctl_t     ctl   [ROWS];

  // Row 0 entry: addend and bias share the first adder's free input
  assign sum_p[0] = (acc_en ? acc_in : '0) + ROW_BIAS;
  assign vld_p[0] = in_valid;
  assign a_p[0]   = op_a;
  assign q_p[0]   = {{(BX_W-B_W){op_b[B_W-1]}}, op_b, 1'b0};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    booth_digit_enc u_enc (
      .trip (q_p[r][2:0]),
      .ctl  (ctl[r])
    );

    booth_row_add #(.A_W(A_W), .W(W), .SHIFT(2*r)) u_add (
      .sum_in  (sum_p[r]),
      .a       (a_p[r]),
      .ctl     (ctl[r]),
      .sum_out (sum_n[r])
    );

    if (PIPE) begin : g_reg
      logic         vld_q;
      logic [W-1:0] sum_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_p[r];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sum_q <= '0;
        else if (vld_p[r]) sum_q <= sum_n[r];
      end

      assign vld_p[r+1] = vld_q;
      assign sum_p[r+1] = sum_q;

      if (r < ROWS - 1) begin : g_fwd
        logic [Q_W-1:0] q_n;
        logic [Q_W-1:0] q_q;
        logic [A_W-1:0] a_q;

        assign q_n = {2'b00, q_p[r][Q_W-1:2]};

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q_q <= '0;
            a_q <= '0;
          end else if (vld_p[r]) begin
            q_q <= q_n;
            a_q <= a_p[r];
          end
        end

        assign q_p[r+1] = q_q;
        assign a_p[r+1] = a_q;
      end
    end else begin : g_comb
      assign vld_p[r+1] = vld_p[r];
      assign sum_p[r+1] = sum_n[r];
      if (r < ROWS - 1) begin : g_fwd
        assign q_p[r+1] = {2'b00, q_p[r][Q_W-1:2]};
        assign a_p[r+1] = a_p[r];
      end
    end
  end

  assign result    = sum_p[ROWS];
  assign out_valid = vld_p[ROWS];

endmodule

// File: rtl/booth_row_mac_chk.sv
module booth_row_mac_chk #(
  parameter int A_W  = 8,
  parameter int B_W  = 8,
  parameter bit PIPE = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [A_W-1:0]     op_a,
  input logic [B_W-1:0]     op_b,
  input logic [A_W+B_W-1:0] acc_in,
  input logic               acc_en,
  input logic               out_valid,
  input logic [A_W+B_W-1:0] result
);

  localparam int W    = A_W + B_W;
  localparam int ROWS = B_W / 2 + 1;

  logic signed [W-1:0] ax, bx;
  logic [W-1:0] exp_now;

  always_comb begin
    ax      = {{B_W{op_a[A_W-1]}}, op_a};
    bx      = {{A_W{op_b[B_W-1]}}, op_b};
    exp_now = W'(ax * bx) + (acc_en ? acc_in : '0);
  end

  if (PIPE) begin : g_seq
    logic         v_d   [ROWS];
    logic         en_d  [ROWS];
    logic [W-1:0] exp_d [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < ROWS; i++) begin
          v_d[i]   <= 1'b0;
          en_d[i]  <= 1'b0;
          exp_d[i] <= '0;
        end
      end else begin
        v_d[0]   <= in_valid;
        en_d[0]  <= acc_en;
        exp_d[0] <= exp_now;
        for (int i = 1; i < ROWS; i++) begin
          v_d[i]   <= v_d[i-1];
          en_d[i]  <= en_d[i-1];
          exp_d[i] <= exp_d[i-1];
        end
      end
    end

    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v_d[ROWS-1]);

    assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !en_d[ROWS-1]) |-> (result == exp_d[ROWS-1]));

    assert_mac_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && en_d[ROWS-1]) |-> (result == exp_d[ROWS-1]));

    assert_idle_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_valid);
  end else begin : g_comb
    always_comb begin
      if (rst_n && in_valid) begin
        assert_valid_latency_R5: assert (out_valid);
        assert_product_R1: assert (result == exp_now);
      end
    end
  end

endmodule

bind booth_row_mac booth_row_mac_chk #(.A_W(A_W), .B_W(B_W), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .acc_in    (acc_in),
  .acc_en    (acc_en),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/booth_row_mac_test.sv
module booth_row_mac_test;

  localparam int A_W  = 8;
  localparam int B_W  = 8;
  localparam int W    = A_W + B_W;
  localparam int ROWS = B_W / 2 + 1;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic [W-1:0]   acc_in;
  logic           acc_en;
  logic           out_valid;
  logic [W-1:0]   result;

  int checks = 0;
  int errors = 0;
  int wr = 0;
  int rd = 0;
  logic [W-1:0] exp_mem [256];
  int           tag_mem [256];
  logic [31:0]  rng = 32'h1234_5678;

  booth_row_mac #(.A_W(A_W), .B_W(B_W), .PIPE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .acc_en(acc_en), .out_valid(out_valid), .result(result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                                         input logic [W-1:0] acc, input logic en);
    logic signed [W-1:0] sa, sb;
    sa = {{B_W{a[A_W-1]}}, a};
    sb = {{A_W{b[B_W-1]}}, b};
    return W'(sa * sb) + (en ? acc : '0);
  endfunction

  function automatic logic [31:0] next_rng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input bit ok, input int req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  // Result monitor: order and value of every finished operation (R6)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd < wr) begin
        check(result == exp_mem[rd], tag_mem[rd], result, exp_mem[rd]);
        rd++;
      end else begin
        check(1'b0, 6, result, '0);
      end
    end
  end

  task automatic issue(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                       input logic [W-1:0] acc, input logic en, input int req);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a; op_b = b; acc_in = acc; acc_en = en;
    exp_mem[wr] = model(a, b, acc, en);
    tag_mem[wr] = req;
    wr++;
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (ROWS + 2) @(negedge clk);
  endtask

  // R7: idle output after reset
  task automatic test_reset_r7();
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0; acc_in = '0; acc_en = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, 7, W'(out_valid), '0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, 7, W'(out_valid), '0);
    end
  endtask

  // R1: plain signed products
  task automatic test_product_r1();
    issue(8'd3, 8'd5, '0, 1'b0, 1);
    issue(8'hF9, 8'd9, '0, 1'b0, 1);
    issue(8'd0, 8'h5A, '0, 1'b0, 1);
    issue(8'd127, 8'd127, '0, 1'b0, 1);
    issue(8'hFF, 8'hFF, '0, 1'b0, 1);
    drain();
  endtask

  // R2: multiply-accumulate with wrap
  task automatic test_mac_r2();
    issue(8'd10, 8'd20, 16'd1000, 1'b1, 2);
    issue(8'hF6, 8'd20, 16'hFF00, 1'b1, 2);
    issue(8'd127, 8'd127, 16'h7FFF, 1'b1, 2);
    issue(8'h80, 8'h80, 16'hC000, 1'b1, 2);
    drain();
  endtask

  // R3: addend ignored when disabled
  task automatic test_acc_off_r3();
    issue(8'd7, 8'd6, 16'hBEEF, 1'b0, 3);
    issue(8'd7, 8'd6, 16'h0000, 1'b0, 3);
    issue(8'h81, 8'h33, 16'hFFFF, 1'b0, 3);
    drain();
  endtask

  // R4: most-negative operands
  task automatic test_extremes_r4();
    issue(8'h80, 8'h80, '0, 1'b0, 4);
    issue(8'h80, 8'd127, '0, 1'b0, 4);
    issue(8'd127, 8'h80, '0, 1'b0, 4);
    issue(8'h80, 8'd1, '0, 1'b0, 4);
    issue(8'h80, 8'hFF, '0, 1'b0, 4);
    drain();
  endtask

  // R8: multipliers covering every recoding triplet
  task automatic test_triplets_r8();
    logic [B_W-1:0] pats [8];
    pats = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h7E, 8'h81, 8'h0F, 8'hF0};
    for (int i = 0; i < 8; i++) issue(8'hB5, pats[i], '0, 1'b0, 8);
    for (int i = 0; i < 8; i++) issue(8'h4B, pats[i], '0, 1'b0, 8);
    drain();
  endtask

  // R5: exact latency of one isolated operation
  task automatic test_latency_r5();
    int seen;
    seen = -1;
    issue(8'd2, 8'd3, '0, 1'b0, 5);
    for (int k = 1; k <= ROWS + 2; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (out_valid && seen < 0) seen = k;
    end
    check(seen == ROWS, 5, W'(seen), W'(ROWS));
    drain();
  endtask

  // R6: back-to-back random stream, all results returned in order
  task automatic test_stream_r6();
    for (int i = 0; i < 40; i++) begin
      rng = next_rng(rng);
      issue(rng[7:0], rng[15:8], {rng[31:24], rng[23:16]}, rng[3], 6);
    end
    drain();
    check(rd == wr, 6, W'(rd), W'(wr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, actual %0d expected %0d results", rd, wr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset_r7();
    test_product_r1();
    test_mac_r2();
    test_acc_off_r3();
    test_extremes_r4();
    test_triplets_r8();
    test_latency_r5();
    test_stream_r6();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule